// File: doc/BRIEF.md
# Oversampling Bit-Timing Generator with Majority Vote

This block produces the timing strobes for a serial receiver and transmitter on a single-wire bus. A 12-bit prescaler divides the system clock into sample ticks. A 6-bit in-bit counter then groups a programmable number of those ticks into one bit period and flags the last tick of each bit as the bit boundary. The resulting bit rate is the clock frequency divided by N·(P+1), where P is the prescaler value and N is the samples-per-bit value.

On the receive side, the raw line is captured on three consecutive sample ticks around the middle of each bit. The three captures are reduced by a majority vote to one received bit, which is presented with a one-cycle valid pulse. An align pulse, normally raised by framing logic when it sees a start edge, restarts both counters so that bit 0 begins at that edge.

Configuration is double-buffered: new prescaler or samples-per-bit inputs are taken up only at a bit boundary or on an align pulse, never partway through a bit.

Top module: `baud_vote_gen`

## Requirements
- R1: After reset, the active prescaler value is 0 and the active samples-per-bit value is 32. A tick is therefore raised in every cycle from the first cycle after reset, and the first bit strobe falls on the 32nd tick. `rxBitValid` is low in the reset state.
- R2: With an active prescaler value P, `sampleTick` is high for one cycle in every P+1 cycles.
- R3: With an active samples-per-bit value N, `bitStrobe` is high exactly on every Nth tick, counted from the start of the bit. It is always raised together with `sampleTick`.
- R4: A samples-per-bit input below 8, including 0, is taken up as 8.
- R5: Number the ticks of a bit from 0. The line is sampled on ticks floor(N/2)-1, floor(N/2) and floor(N/2)+1. `rxBit` is the majority of those three samples and is valid in the cycle after the third sample tick.
- R6: In the cycle in which `align` is high, no tick or strobe is raised. Both counters restart, and the current inputs become the active configuration. The first tick then comes P+1 cycles after the align cycle.
- R7: A change of the prescaler or samples-per-bit inputs has no effect until the next bit strobe. The bit that follows that strobe uses the new values.
- R8: `rxBitValid` is a single-cycle pulse, raised once per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| prescale | input | 12 | Prescaler value P; a tick is raised every P+1 cycles |
| samplesPerBit | input | 6 | Sample ticks per bit N; values below 8 are taken as 8 |
| rxLine | input | 1 | Raw receive line, synchronous to clk |
| align | input | 1 | Restart pulse for both counters |
| sampleTick | output | 1 | One-cycle sample tick |
| bitStrobe | output | 1 | High on the last tick of each bit |
| rxBit | output | 1 | Majority-voted received bit |
| rxBitValid | output | 1 | One-cycle pulse marking `rxBit` as new |

## Verification
An off-by-one in the prescaler count shifts the very next `sampleTick` by one cycle, so the error shows within P+2 cycles of an align. A wrong in-bit count or a wrong clamp moves `bitStrobe` within the first bit. An error in the vote positions changes `rxBit`, or the cycle in which `rxBitValid` rises, in the first bit whose line pattern differs across the sampled ticks. A configuration taken up too early or too late shows as a displaced tick or strobe in the first bit after an input change.

// File: rtl/baud_vote_pkg.sv
package baud_vote_pkg;
  localparam int PRE_W     = 12;
  localparam int SPB_W     = 6;
  localparam int SPB_RESET = 32;
  localparam int SPB_MIN   = 8;

  // control-to-datapath strobes
  typedef struct packed {
    logic tick;
    logic bitEnd;
    logic vote0;
    logic vote1;
    logic vote2;
  } strobeT;
endpackage

// File: rtl/baud_vote_ctrl.sv
module baud_vote_ctrl
  import baud_vote_pkg::*;
#(
  parameter int PreW     = PRE_W,
  parameter int SpbW     = SPB_W,
  parameter int SpbReset = SPB_RESET,
  parameter int SpbMin   = SPB_MIN
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PreW-1:0] prescale,
  input  logic [SpbW-1:0] samplesPerBit,
  input  logic            align,
  output strobeT          strb
);
  localparam logic [SpbW-1:0] ONE_S  = SpbW'(1);
  localparam logic [SpbW-1:0] MIN_S  = SpbW'(SpbMin);
  localparam logic [SpbW-1:0] RST_S  = SpbW'(SpbReset);

  logic [PreW-1:0] preCnt, activePre;
  logic [SpbW-1:0] bitCnt, activeN, clampedN, halfN;
  logic            tickRaw, lastSample;

  assign clampedN   = (samplesPerBit < MIN_S) ? MIN_S : samplesPerBit;
  assign halfN      = activeN >> 1;
  assign tickRaw    = !align && (preCnt == activePre);
  assign lastSample = (bitCnt == activeN - ONE_S);

  always_comb begin
    strb.tick   = tickRaw;
    strb.bitEnd = tickRaw && lastSample;
    strb.vote0  = tickRaw && (bitCnt == halfN - ONE_S);
    strb.vote1  = tickRaw && (bitCnt == halfN);
    strb.vote2  = tickRaw && (bitCnt == halfN + ONE_S);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt    <= '0;
      bitCnt    <= '0;
      activePre <= '0;
      activeN   <= RST_S;
    end else if (align) begin
      preCnt    <= '0;
      bitCnt    <= '0;
      activePre <= prescale;
      activeN   <= clampedN;
    end else if (tickRaw) begin
      preCnt <= '0;
      if (lastSample) begin
        bitCnt    <= '0;
        activePre <= prescale;
        activeN   <= clampedN;
      end else begin
        bitCnt <= bitCnt + ONE_S;
      end
    end else begin
      preCnt <= preCnt + PreW'(1);
    end
  end
endmodule

// File: rtl/baud_vote_dp.sv
module baud_vote_dp
  import baud_vote_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strb,
  input  logic   rxLine,
  output logic   rxBit,
  output logic   rxBitValid
);
  logic sampA, sampB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA      <= 1'b1;
      sampB      <= 1'b1;
      rxBit      <= 1'b1;
      rxBitValid <= 1'b0;
    end else begin
      rxBitValid <= strb.vote2;
      if (strb.vote0) sampA <= rxLine;
      if (strb.vote1) sampB <= rxLine;
      if (strb.vote2) rxBit <= (sampA & sampB) | (sampA & rxLine) | (sampB & rxLine);
    end
  end
endmodule

// File: rtl/baud_vote_gen.sv
module baud_vote_gen
  import baud_vote_pkg::*;
#(
  parameter int PreW = PRE_W,
  parameter int SpbW = SPB_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PreW-1:0] prescale,
  input  logic [SpbW-1:0] samplesPerBit,
  input  logic            rxLine,
  input  logic            align,
  output logic            sampleTick,
  output logic            bitStrobe,
  output logic            rxBit,
  output logic            rxBitValid
);
  strobeT strb;

  baud_vote_ctrl #(.PreW(PreW), .SpbW(SpbW)) u_ctrl (
    .clk(clk), .rstN(rstN), .prescale(prescale),
    .samplesPerBit(samplesPerBit), .align(align), .strb(strb)
  );

  baud_vote_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxLine(rxLine),
    .rxBit(rxBit), .rxBitValid(rxBitValid)
  );

  assign sampleTick = strb.tick;
  assign bitStrobe  = strb.bitEnd;
endmodule

// File: rtl/baud_vote_chk.sv
module baud_vote_chk (
  input logic clk,
  input logic rstN,
  input logic align,
  input logic sampleTick,
  input logic bitStrobe,
  input logic rxBitValid
);
  // R3
  strobe_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> sampleTick);
  // R6
  align_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    align |-> (!sampleTick && !bitStrobe));
  // R6
  align_no_early_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    align |=> !bitStrobe);
  // R8
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxBitValid |=> !rxBitValid);
  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |=> !bitStrobe);
endmodule

bind baud_vote_gen baud_vote_chk u_chk (
  .clk(clk), .rstN(rstN), .align(align), .sampleTick(sampleTick),
  .bitStrobe(bitStrobe), .rxBitValid(rxBitValid)
);

// File: tb/baud_vote_gen_tb.sv
module baud_vote_gen_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] prescale = '0;
  logic [5:0]  samplesPerBit = 6'd32;
  logic        rxLine = 1'b1;
  logic        align = 1'b0;
  logic        sampleTick, bitStrobe, rxBit, rxBitValid;
  int          total = 0;
  int          bad = 0;

  baud_vote_gen u_dut (
    .clk(clk), .rstN(rstN), .prescale(prescale), .samplesPerBit(samplesPerBit),
    .rxLine(rxLine), .align(align), .sampleTick(sampleTick), .bitStrobe(bitStrobe),
    .rxBit(rxBit), .rxBitValid(rxBitValid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp, input int cyc);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  function automatic int clampN(input int n);
    return (n < 8) ? 8 : n;
  endfunction

  function automatic logic lineVal(input int c, input int run);
    return ((c * 13 + run * 7) % 7) < 3;
  endfunction

  function automatic logic maj(input logic a, input logic b, input logic d);
    return (a & b) | (a & d) | (b & d);
  endfunction

  // align with (p1,n1); switch inputs to (p2,n2) one cycle later
  task automatic runCfg(input int p1, input int n1, input int p2, input int n2, input int run);
    int n1e = clampN(n1);
    int n2e = clampN(n2);
    int t1 = n1e * (p1 + 1);
    int tEnd = t1 + 2 * n2e * (p2 + 1) + 2;
    logic e0 = 1'b0, e1 = 1'b0, expBit = 1'b0, expValid = 1'b0;
    logic nextBit = 1'b0, nextValid = 1'b0;
    string tickReq = (n1 < 8 || n2 < 8) ? "R4" : "R3";
    @(posedge clk); #1;
    prescale = 12'(p1); samplesPerBit = 6'(n1); align = 1'b1;
    @(negedge clk);
    chk("R6", sampleTick, 1'b0, 0);
    @(posedge clk); #1;
    align = 1'b0; prescale = 12'(p2); samplesPerBit = 6'(n2);
    rxLine = lineVal(1, run);
    for (int c = 1; c <= tEnd; c++) begin
      int cp, pp, nn, pos;
      logic tickE, strobeE;
      if (c <= t1) begin cp = c; pp = p1; nn = n1e; end
      else begin cp = c - t1; pp = p2; nn = n2e; end
      tickE = (cp % (pp + 1)) == 0;
      pos = tickE ? ((cp / (pp + 1) - 1) % nn) : -1;
      strobeE = tickE && (pos == nn - 1);
      @(negedge clk);
      chk((c <= t1) ? "R6/R2" : "R7/R2", sampleTick, tickE, c);
      chk((c <= t1) ? tickReq : "R7", bitStrobe, strobeE, c);
      chk("R8", rxBitValid, expValid, c);
      if (expValid) chk("R5", rxBit, expBit, c);
      nextValid = 1'b0;
      if (tickE && pos == nn / 2 - 1) e0 = lineVal(c, run);
      if (tickE && pos == nn / 2)     e1 = lineVal(c, run);
      if (tickE && pos == nn / 2 + 1) begin
        nextBit = maj(e0, e1, lineVal(c, run));
        nextValid = 1'b1;
      end
      expValid = nextValid;
      if (nextValid) expBit = nextBit;
      @(posedge clk); #1;
      rxLine = lineVal(c + 1, run);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int run = 0;
    int nList[7] = '{0, 5, 8, 9, 16, 33, 63};
    // R1: reset state, then default timing with different inputs present
    repeat (3) @(posedge clk);
    #1;
    prescale = 12'd5; samplesPerBit = 6'd10;
    rstN = 1'b1;
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      chk("R1", sampleTick, 1'b1, c);
      chk("R1", bitStrobe, (c == 31), c);
      if (c == 0) chk("R1", rxBitValid, 1'b0, c);
    end
    // R7: new prescaler taken up at first boundary -> no tick right after
    @(negedge clk);
    chk("R7", sampleTick, 1'b0, 32);
    // sweeps
    for (int pi = 0; pi < 3; pi++) begin
      for (int ni = 0; ni < 7; ni++) begin
        int p1 = (pi == 2) ? 3 : pi;
        runCfg(p1, nList[ni], (p1 + 2) % 4, nList[(ni + 3) % 7], run);
        run++;
      end
    end
    // larger prescaler
    runCfg(37, 8, 1, 63, run);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule